// File: doc/BRIEF.md
# Seven-to-One Pixel Link Serializer

This block turns one pixel per pixel period into five serial streams. Each pixel carries 8-bit red, green and blue values plus horizontal sync, vertical sync, a data-valid flag and a spare bit. These are packed into a 28-bit word using a fixed, non-monotonic bit placement. The word is cut into four 7-bit groups, and each group leaves on its own data lane. A fifth lane carries a framing pattern that acts as the forwarded pixel clock.

The block runs entirely on a bit-rate clock at seven times the pixel rate. An internal 0..6 phase counter marks the frame. The strobe `take` is high during the last bit slot of each frame. The pixel fields present at the end of that cycle are captured into the lane shift registers. They are then sent during the next seven bit slots, most significant position of each group first. The source updates its pixel inputs whenever it sees `take` high. Differential drivers and clock multiplication are outside this block.

Top module: `pixel_link_ser`

## Requirements
- R1: While and right after reset, all four data lanes output 0, the clock lane outputs 1 and `take` is low.
- R2: `take` is high for exactly one fast cycle in every seven. The first such cycle is the seventh fast cycle after reset release, counting the release cycle as the first.
- R3: Red is placed in word positions as follows. Positions 0-4 hold red bits 0-4. Position 5 holds red bit 7, position 6 holds red bit 5, and position 27 holds red bit 6.
- R4: Green is placed in word positions as follows. Positions 7-9 hold green bits 0-2. Positions 10-11 hold green bits 6-7. Positions 12-14 hold green bits 3-5.
- R5: Blue is placed in word positions as follows. Position 15 holds blue bit 0. Positions 16-17 hold blue bits 6-7. Positions 18-22 hold blue bits 1-5.
- R6: The control bits take positions 23-26: position 23 is the spare bit, 24 is hsync, 25 is vsync and 26 is data-valid.
- R7: Data lane L sends word positions 7L+6 down to 7L, one per fast cycle. The highest position is sent in the first fast cycle after the capturing edge.
- R8: In every frame the clock lane sends 1,1,0,0,0,1,1. The first of these bits coincides with the first data bit of the frame.
- R9: With parameter PASS_RSVD set to 0, position 23 is always sent as 0, whatever the spare input is.
- R10: Pixel inputs that change while `take` is low have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| px_red | input | 8 | Red value |
| px_green | input | 8 | Green value |
| px_blue | input | 8 | Blue value |
| px_hsync | input | 1 | Horizontal sync |
| px_vsync | input | 1 | Vertical sync |
| px_valid | input | 1 | Data-valid flag |
| px_spare | input | 1 | Spare bit |
| take | output | 1 | High in the slot whose closing edge captures the pixel inputs |
| lane_data | output | 4 | Serial data lanes; bit L is lane L |
| lane_clk | output | 1 | Forwarded clock lane |

## Verification
The bench builds two copies. One uses the default parameters and the other uses PASS_RSVD = 0; both keep the 1100011 clock pattern. Each of the 28 pixel inputs is walked as a single one and as a single zero through both copies, followed by all-zero, all-ones and mixed words. Together these pin every word position to its source bit and its lane slot. Because both copies share the same stimulus, the spare-bit suppression is compared directly against the copy that passes it. The inputs are scrambled mid-frame to show that only the capturing edge matters.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int LANES = 4;
  localparam int BITS  = 7;
  localparam int WORD  = LANES * BITS;
  localparam int PW    = $clog2(BITS);
  localparam int SPARE_POS = 23;

  typedef logic [WORD-1:0] word_t;

  // Fixed placement of colour and control bits into the 28-bit word.
  function automatic word_t pack_pixel(input logic [7:0] r, input logic [7:0] g,
                                       input logic [7:0] b, input logic hs,
                                       input logic vs, input logic dv, input logic sp);
    word_t w;
    w[4:0]   = r[4:0];
    w[5]     = r[7];
    w[6]     = r[5];
    w[9:7]   = g[2:0];
    w[11:10] = g[7:6];
    w[14:12] = g[5:3];
    w[15]    = b[0];
    w[17:16] = b[7:6];
    w[22:18] = b[5:1];
    w[23]    = sp;
    w[24]    = hs;
    w[25]    = vs;
    w[26]    = dv;
    w[27]    = r[6];
    return w;
  endfunction
endpackage

// File: rtl/pls_phase.sv
module pls_phase #(
  parameter int N  = 7,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          last
);
  localparam logic [PW-1:0] TOP = PW'(N - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      phase <= '0;
    else if (last)   phase <= '0;
    else             phase <= phase + 1'b1;
  end

  assign last = (phase == TOP);

  a_r2_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= TOP);
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (phase == '0));
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> (phase == $past(phase) + 1'b1));
endmodule

// File: rtl/pls_shift.sv
module pls_shift #(
  parameter int W = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic         sout
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sreg <= RST_VAL;
    else if (load) sreg <= din;
    else           sreg <= {sreg[W-2:0], 1'b0};
  end

  assign sout = sreg[W-1];

  // R7: a load places the whole group, MSB first on the line
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sreg == $past(din)));
  // R10: between loads the register only shifts; input changes do not enter
  a_r10_shift_only: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sreg[W-1:1] == $past(sreg[W-2:0])));
endmodule

// File: rtl/pixel_link_ser.sv
module pixel_link_ser
  import pls_pkg::*;
#(
  parameter bit              PASS_RSVD   = 1'b1,
  parameter logic [BITS-1:0] CLK_PATTERN = 7'b1100011
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic [7:0]       px_red,
  input  logic [7:0]       px_green,
  input  logic [7:0]       px_blue,
  input  logic             px_hsync,
  input  logic             px_vsync,
  input  logic             px_valid,
  input  logic             px_spare,
  output logic             take,
  output logic [LANES-1:0] lane_data,
  output logic             lane_clk
);
  localparam int SPARE_LANE = SPARE_POS / BITS;
  localparam int SPARE_SLOT = BITS - 1 - (SPARE_POS % BITS);

  logic [PW-1:0] phase;
  logic          frame_last;
  logic          spare_eff;
  word_t         frame_word;

  pls_phase #(.N(BITS), .PW(PW)) u_phase (
    .clk   (clk_bit),
    .rst_n (rst_n),
    .phase (phase),
    .last  (frame_last)
  );

  generate
    if (PASS_RSVD) begin : g_spare_pass
      assign spare_eff = px_spare;
    end else begin : g_spare_zero
      assign spare_eff = 1'b0;
    end
  endgenerate

  assign frame_word = pack_pixel(px_red, px_green, px_blue,
                                 px_hsync, px_vsync, px_valid, spare_eff);
  assign take = frame_last;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      pls_shift #(.W(BITS), .RST_VAL('0)) u_lane (
        .clk   (clk_bit),
        .rst_n (rst_n),
        .load  (frame_last),
        .din   (frame_word[l*BITS +: BITS]),
        .sout  (lane_data[l])
      );
    end
  endgenerate

  pls_shift #(.W(BITS), .RST_VAL(CLK_PATTERN)) u_clk_lane (
    .clk   (clk_bit),
    .rst_n (rst_n),
    .load  (frame_last),
    .din   (CLK_PATTERN),
    .sout  (lane_clk)
  );

  // R8: clock lane bit tracks the frame phase
  a_r8_clk_lane: assert property (@(posedge clk_bit) disable iff (!rst_n)
    lane_clk == CLK_PATTERN[BITS-1-int'(phase)]);
  // R9: suppressed spare bit never reaches its lane slot
  a_r9_spare_zero: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (!PASS_RSVD && (int'(phase) == SPARE_SLOT)) |-> !lane_data[SPARE_LANE]);
  // R2: strobe spacing
  a_r2_take_gap: assert property (@(posedge clk_bit) disable iff (!rst_n)
    take |=> !take);
endmodule

// File: tb/sim_pixel_link_ser.sv
module sim_pixel_link_ser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] r, g, b;
  logic       hs, vs, dv, sp;
  logic       take0, take1;
  logic [3:0] d0, d1;
  logic       c0, c1;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  pixel_link_ser u0 (.clk_bit(clk), .rst_n(rst_n), .px_red(r), .px_green(g),
    .px_blue(b), .px_hsync(hs), .px_vsync(vs), .px_valid(dv), .px_spare(sp),
    .take(take0), .lane_data(d0), .lane_clk(c0));

  pixel_link_ser #(.PASS_RSVD(1'b0)) u1 (.clk_bit(clk), .rst_n(rst_n), .px_red(r),
    .px_green(g), .px_blue(b), .px_hsync(hs), .px_vsync(vs), .px_valid(dv),
    .px_spare(sp), .take(take1), .lane_data(d1), .lane_clk(c1));

  // Logical stimulus: [7:0] red, [15:8] green, [23:16] blue, 24 hs, 25 vs, 26 dv, 27 spare
  function automatic logic wire_pos(input logic [27:0] s, input int p);
    logic [7:0] rr, gg, bb;
    rr = s[7:0]; gg = s[15:8]; bb = s[23:16];
    if (p <= 4)       return rr[p];
    else if (p == 5)  return rr[7];
    else if (p == 6)  return rr[5];
    else if (p == 27) return rr[6];
    else if (p <= 9)  return gg[p-7];
    else if (p <= 11) return gg[p-4];
    else if (p <= 14) return gg[p-9];
    else if (p == 15) return bb[0];
    else if (p <= 17) return bb[p-10];
    else if (p <= 22) return bb[p-17];
    else if (p == 23) return s[27];
    else if (p == 24) return s[24];
    else if (p == 25) return s[25];
    else              return s[26];
  endfunction

  function automatic string tag_of(input int p);
    if (p <= 6 || p == 27) return "R3";
    else if (p <= 14)      return "R4";
    else if (p <= 22)      return "R5";
    else                   return "R6";
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic apply(input logic [27:0] s);
    r = s[7:0]; g = s[15:8]; b = s[23:16];
    hs = s[24]; vs = s[25]; dv = s[26]; sp = s[27];
  endtask

  task automatic frame(input logic [27:0] s);
    logic [6:0] pat;
    pat = 7'b1100011;
    while (!take0) @(negedge clk);
    apply(s);
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (k == 0) apply(~s ^ 28'h5A3C96F); // R10: scramble after capture
      for (int l = 0; l < 4; l++) begin
        int p;
        logic e;
        p = 7*l + 6 - k;
        e = wire_pos(s, p);
        check({tag_of(p), "/R7/R10 u0"}, d0[l], e);
        if (p == 23) check("R9 u1 spare", d1[l], 1'b0);
        else         check({tag_of(p), "/R7 u1"}, d1[l], e);
      end
      check("R8 clock lane", c0, pat[6-k]);
      check("R2 take", take0, (k == 6));
    end
  endtask

  initial begin
    apply('0);
    repeat (3) @(negedge clk);
    check("R1 data lanes in reset", |d0, 1'b0);
    check("R1 clock lane in reset", c0, 1'b1);
    check("R1 take in reset", take0, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      check("R1 data lanes after reset", |d0, 1'b0);
      check("R2 take before first frame", take0, 1'b0);
      @(negedge clk);
    end
    check("R2 first take", take0, 1'b1);
    for (int i = 0; i < 28; i++) frame(28'd1 << i);
    for (int i = 0; i < 28; i++) frame(~(28'd1 << i));
    frame(28'h0000000);
    frame(28'hFFFFFFF);
    frame(28'hA5C3E17);
    frame(28'h8F0F00F);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule